// File: doc/BRIEF.md
# Serial SRAM Host Command Controller

This block sits between an on-chip requester and an external serial SRAM that can run its bus one, two or four data lanes wide. A requester presents an operation (read or write), a target lane width, a 17-bit byte address and a byte count. The controller then produces the chip-select and serial clock, sends the command and address, and moves the data. Write bytes are taken through an acknowledge pulse. Read bytes come back with a one-cycle valid strobe.

The controller keeps a shadow copy of the lane width the memory is currently using. When a request asks for a different width, the controller first runs separate chip-select framed mode-change commands at the old width, and only then runs the data transfer. The serial clock is derived from the system clock by a fixed half-period count, so the low and high phases each last a programmable number of system cycles. Every frame is followed by an enforced chip-select high gap.

Top module: `sram_host_ctrl`

## Requirements
- R1: After reset, sram_cs_no is high, sram_sck_o is low, sio_oe_o is 0000, busy_o is low and req_ready_o is high.
- R2: A data frame starts with opcode 03h (read) or 02h (write), followed by a 24-bit address whose bits 23..17 are zero. Both go out most significant bit first. Lane use depends on the width: at width code 0 (single) the host drives sio[0] and reads sio[1]; at code 1 (dual) it uses sio[1:0]; at code 2 (quad) it uses sio[3:0]. The higher-numbered lane always carries the more significant bit.
- R3: A frame has exactly 32/L address-and-opcode rising SCK edges, plus 8/L per data byte, plus the dummy edges of R4, where L is 1, 2 or 4 lanes. A mode-change frame has 8/L edges.
- R4: A read inserts 4 dummy SCK cycles at dual width, 2 at quad width and none at single width, between the last address edge and the first data edge.
- R5: Each SCK low phase and high phase lasts HALF_CYC system cycles. Outputs change with the falling edge and read data is sampled at the rising edge. SCK is low whenever chip select is high.
- R6: After reset the shadow width is single. Width code 3 is treated as single. Moving from single to dual sends 3Bh, and from single to quad sends 38h. Leaving dual or quad first sends FFh at the current width; if the target is not single, the matching enable opcode follows. Each opcode is its own frame and comes before the data frame.
- R7: During a dual or quad read, the host stops driving the data lanes from the first dummy cycle until chip select rises. At single and dual width, sio[3] is driven high while chip select is low.
- R8: A request moves req_len_i+1 bytes. There is one wdata_ack_o pulse per write byte taken from wdata_i, and one rdata_valid_o pulse per read byte. The memory pointer keeps advancing through the whole frame, including the wrap from 1FFFFh to 0.
- R9: Chip select stays high for at least GAP_CYC system cycles between two frames.
- R10: busy_o is high from the accepting cycle until chip select has returned high and the gap has elapsed. req_ready_o is high only while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_width_i | input | 2 | Lane width code: 0 single, 1 dual, 2 quad |
| req_addr_i | input | ADDR_W | Start byte address |
| req_len_i | input | LEN_W | Byte count minus one |
| wdata_i | input | 8 | Write byte on offer |
| wdata_ack_o | output | 1 | Pulse: current write byte taken |
| rdata_o | output | 8 | Read byte |
| rdata_valid_o | output | 1 | Pulse: rdata_o valid |
| busy_o | output | 1 | Transaction in progress |
| sram_cs_no | output | 1 | Memory chip select, active low |
| sram_sck_o | output | 1 | Memory serial clock |
| sio_o | output | 4 | Lane output values |
| sio_oe_o | output | 4 | Lane output enables |
| sio_i | input | 4 | Lane input values |

## Verification
The bench builds the controller with its defaults: a 3-cycle half period, a 3-cycle chip-select gap, 17 address bits and an 8-bit length. It attaches a behavioural lane-switching memory model. The short gap and half period keep each frame to a few hundred cycles. This lets the bench walk every width-to-width transition, each followed by a write and a read-back of one to four bytes. The 17-bit address lets a three-byte quad read cross the top of the array.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {W_SPI = 2'd0, W_DUAL = 2'd1, W_QUAD = 2'd2} width_e;
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CMD, S_DUMMY, S_WDATA, S_RDATA, S_TAIL, S_GAP} state_e;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_QUAD  = 8'h38;
  localparam logic [7:0] OP_DUAL  = 8'h3B;
  localparam logic [7:0] OP_SPI   = 8'hFF;

  function automatic logic [5:0] byte_beats(width_e w);
    return 6'd8 >> w;
  endfunction

  function automatic logic [5:0] dummy_beats(width_e w);
    case (w)
      W_DUAL:  return 6'd4;
      W_QUAD:  return 6'd2;
      default: return 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/shc_clk_div.sv
module shc_clk_div #(
  parameter int HALF_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_CYC) + 1;
  logic [CW-1:0] cnt;

  assign tick_o = run_i && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= '0;
    else if (!run_i || tick_o)  cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/shc_lane_io.sv
module shc_lane_io import shc_pkg::*; (
  input  width_e      width_i,
  input  logic        active_i,
  input  logic        drive_i,
  input  logic [3:0]  tx_i,
  input  logic [3:0]  sio_i,
  output logic [3:0]  sio_o,
  output logic [3:0]  sio_oe_o,
  output logic [3:0]  rx_o
);
  always_comb begin
    sio_o    = '0;
    sio_oe_o = '0;
    rx_o     = '0;
    case (width_i)
      W_QUAD: begin
        sio_o    = tx_i;
        sio_oe_o = {4{drive_i}};
        rx_o     = sio_i;
      end
      W_DUAL: begin
        sio_o    = {1'b1, 1'b0, tx_i[3:2]};
        sio_oe_o = {1'b1, 1'b0, drive_i, drive_i};
        rx_o     = {2'b00, sio_i[1:0]};
      end
      default: begin
        sio_o    = {1'b1, 2'b00, tx_i[3]};
        sio_oe_o = 4'b1001;
        rx_o     = {3'b000, sio_i[1]};
      end
    endcase
    if (!active_i) sio_oe_o = '0;
  end
endmodule

// File: rtl/sram_host_ctrl.sv
module sram_host_ctrl import shc_pkg::*; #(
  parameter int HALF_CYC = 3,
  parameter int GAP_CYC  = 3,
  parameter int LEN_W    = 8,
  parameter int ADDR_W   = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [1:0]        req_width_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [7:0]        wdata_i,
  output logic              wdata_ack_o,
  output logic [7:0]        rdata_o,
  output logic              rdata_valid_o,
  output logic              busy_o,
  output logic              sram_cs_no,
  output logic              sram_sck_o,
  output logic [3:0]        sio_o,
  output logic [3:0]        sio_oe_o,
  input  logic [3:0]        sio_i
);
  localparam int PAD_W = 24 - ADDR_W;
  localparam int GW    = $clog2(GAP_CYC + 1);

  state_e            st;
  width_e            cur_w, tgt_w;
  logic              wr_r, mode_txn, rd_turn;
  logic [ADDR_W-1:0] addr_r;
  logic [LEN_W-1:0]  len_r;
  logic [5:0]        bcnt;
  logic [31:0]       sr;
  logic [7:0]        rx_sr, rx_next, rdata_q, mode_op;
  logic              rvalid_q, wack_q, cs_n_q, sck_q, tick, run;
  logic [GW-1:0]     gap_cnt;
  logic [2:0]        lane_cnt;
  logic [3:0]        rx_bits;

  assign run      = st inside {S_CMD, S_DUMMY, S_WDATA, S_RDATA, S_TAIL};
  assign lane_cnt = 3'd1 << cur_w;
  assign mode_op  = (cur_w != W_SPI) ? OP_SPI : ((tgt_w == W_QUAD) ? OP_QUAD : OP_DUAL);

  shc_clk_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  shc_lane_io u_lanes (
    .width_i(cur_w), .active_i(!cs_n_q), .drive_i(!rd_turn), .tx_i(sr[31:28]),
    .sio_i(sio_i), .sio_o(sio_o), .sio_oe_o(sio_oe_o), .rx_o(rx_bits)
  );

  always_comb begin
    case (cur_w)
      W_DUAL:  rx_next = {rx_sr[5:0], rx_bits[1:0]};
      W_QUAD:  rx_next = {rx_sr[3:0], rx_bits};
      default: rx_next = {rx_sr[6:0], rx_bits[0]};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; cur_w <= W_SPI; tgt_w <= W_SPI;
      wr_r <= 1'b0; mode_txn <= 1'b0; rd_turn <= 1'b0;
      addr_r <= '0; len_r <= '0; bcnt <= '0; sr <= '0;
      rx_sr <= '0; rdata_q <= '0; rvalid_q <= 1'b0; wack_q <= 1'b0;
      cs_n_q <= 1'b1; sck_q <= 1'b0; gap_cnt <= '0;
    end else begin
      rvalid_q <= 1'b0;
      wack_q   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid_i) begin
          tgt_w  <= (req_width_i == 2'd3) ? W_SPI : width_e'(req_width_i);
          wr_r   <= req_write_i;
          addr_r <= req_addr_i;
          len_r  <= req_len_i;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          cs_n_q  <= 1'b0;
          sck_q   <= 1'b0;
          rd_turn <= 1'b0;
          st      <= S_CMD;
          if (cur_w != tgt_w) begin
            mode_txn <= 1'b1;
            sr       <= {mode_op, 24'h0};
            bcnt     <= byte_beats(cur_w);
          end else begin
            mode_txn <= 1'b0;
            sr       <= {wr_r ? OP_WRITE : OP_READ, {PAD_W{1'b0}}, addr_r};
            bcnt     <= 6'd32 >> cur_w;
          end
        end
        S_CMD, S_DUMMY, S_WDATA, S_RDATA: if (tick) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
            if (st == S_RDATA) rx_sr <= rx_next;
          end else begin
            sck_q <= 1'b0;
            if (bcnt != 6'd1) begin
              bcnt <= bcnt - 6'd1;
              sr   <= sr << lane_cnt;
            end else begin
              case (st)
                S_CMD: begin
                  if (mode_txn) st <= S_TAIL;
                  else if (wr_r) begin
                    st <= S_WDATA; sr <= {wdata_i, 24'h0}; wack_q <= 1'b1;
                    bcnt <= byte_beats(cur_w);
                  end else begin
                    rd_turn <= 1'b1;
                    if (dummy_beats(cur_w) != 6'd0) begin
                      st <= S_DUMMY; bcnt <= dummy_beats(cur_w);
                    end else begin
                      st <= S_RDATA; bcnt <= byte_beats(cur_w);
                    end
                  end
                end
                S_DUMMY: begin
                  st <= S_RDATA; bcnt <= byte_beats(cur_w);
                end
                S_WDATA: begin
                  if (len_r == '0) st <= S_TAIL;
                  else begin
                    len_r <= len_r - LEN_W'(1); sr <= {wdata_i, 24'h0};
                    wack_q <= 1'b1; bcnt <= byte_beats(cur_w);
                  end
                end
                default: begin
                  rdata_q <= rx_sr; rvalid_q <= 1'b1;
                  if (len_r == '0) st <= S_TAIL;
                  else begin
                    len_r <= len_r - LEN_W'(1); bcnt <= byte_beats(cur_w);
                  end
                end
              endcase
            end
          end
        end
        S_TAIL: if (tick) begin
          cs_n_q  <= 1'b1;
          gap_cnt <= '0;
          st      <= S_GAP;
          if (mode_txn) cur_w <= (cur_w != W_SPI) ? W_SPI : tgt_w;
        end
        default: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GW'(GAP_CYC - 1)) st <= mode_txn ? S_LOAD : S_IDLE;
        end
      endcase
    end
  end

  assign req_ready_o   = (st == S_IDLE);
  assign busy_o        = (st != S_IDLE);
  assign wdata_ack_o   = wack_q;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rvalid_q;
  assign sram_cs_no    = cs_n_q;
  assign sram_sck_o    = sck_q;

  // R5
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_cs_no |-> !sram_sck_o);
  // R5
  sck_rise_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_sck_o) |-> !sram_cs_no);
  // R10
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> busy_o);
  // R6
  width_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_w != $past(cur_w)) |-> sram_cs_no);
  // R7
  quad_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_cs_no && (st inside {S_DUMMY, S_RDATA}) && cur_w == W_QUAD |-> sio_oe_o == 4'h0);
  // R7
  dual_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_cs_no && (st inside {S_DUMMY, S_RDATA}) && cur_w == W_DUAL |-> sio_oe_o[1:0] == 2'b00);
  // R7
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_cs_no && cur_w != W_QUAD |-> sio_oe_o[3] && sio_o[3]);
  // R8
  rvalid_framed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> !sram_cs_no);
endmodule

// File: tb/sram_lane_model.sv
module sram_lane_model (
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] host_o,
  input  logic [3:0] host_oe,
  output logic [3:0] dout,
  output logic [3:0] dout_en
);
  logic [7:0]  mem [256];
  int          mode = 0;
  int          frames = 0, rises = 0, last_rises = 0, nbits = 0, wbits = 0, sub = 0;
  int          oe_viol = 0, addr_err = 0;
  logic [31:0] hdr;
  logic [7:0]  cmd, wbyte, obyte;
  logic [16:0] ptr;
  logic [15:0] mop_log = '0;

  function automatic int lanes();
    return 1 << mode;
  endfunction
  function automatic int dum();
    return (mode == 1) ? 4 : (mode == 2) ? 2 : 0;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) & 255);
    dout = '0; dout_en = '0; hdr = '0; cmd = '0; wbyte = '0; obyte = '0; ptr = '0;
  end

  always @(negedge cs_n) begin
    frames++; rises = 0; nbits = 0; wbits = 0; sub = 0; hdr = '0; cmd = '0; dout_en = '0;
  end

  always @(posedge cs_n) begin
    dout_en = '0;
    last_rises = rises;
    if (nbits == 8) begin
      mop_log = {mop_log[7:0], cmd};
      if (cmd == 8'h38) mode = 2;
      else if (cmd == 8'h3B) mode = 1;
      else if (cmd == 8'hFF) mode = 0;
    end
  end

  always @(posedge sck) if (!cs_n) begin
    int b;
    b = (mode == 2) ? int'(host_o) : (mode == 1) ? int'(host_o[1:0]) : int'(host_o[0]);
    rises++;
    if (nbits < 32) begin
      hdr = 32'((hdr << lanes()) | b);
      nbits += lanes();
      if (nbits == 8) cmd = hdr[7:0];
      if (nbits == 32) begin
        if (hdr[23:17] != 0) addr_err++;
        ptr = hdr[16:0];
      end
    end else if (cmd == 8'h02) begin
      wbyte = 8'((wbyte << lanes()) | b);
      wbits += lanes();
      if (wbits == 8) begin
        mem[ptr[7:0]] = wbyte; ptr = ptr + 17'd1; wbits = 0;
      end
    end else if (cmd == 8'h03 && mode != 0) begin
      if ((host_oe & 4'((1 << lanes()) - 1)) != 0) oe_viol++;
    end
  end

  always @(negedge sck) if (!cs_n && cmd == 8'h03 && nbits >= 32 && rises >= 32 / lanes() + dum()) begin
    if (sub == 0) begin
      obyte = mem[ptr[7:0]]; ptr = ptr + 17'd1;
    end
    case (mode)
      2:       begin dout = obyte[7:4]; dout_en = 4'hF; end
      1:       begin dout = {2'b00, obyte[7:6]}; dout_en = 4'h3; end
      default: begin dout = {2'b00, obyte[7], 1'b0}; dout_en = 4'h2; end
    endcase
    obyte = 8'(obyte << lanes());
    sub = (sub + lanes()) % 8;
  end
endmodule

// File: tb/sram_host_ctrl_test.sv
module sram_host_ctrl_test;
  localparam int HALF = 3;
  localparam int GAP  = 3;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_width = 0;
  logic [16:0] req_addr = 0;
  logic [7:0]  req_len = 0, wdata = 0;
  logic        req_ready, wack, rvalid, busy, cs_n, sck;
  logic [7:0]  rdata;
  logic [3:0]  sio_o, sio_oe, sio_in, m_dout, m_en;

  int n_chk = 0, n_fail = 0, conflicts = 0, hold_viol = 0, ready_viol = 0;
  int hi_cnt = 0, min_gap = 1000, run = 0, min_half = 1000, max_half = 0, busy_gap_bad = 0;
  logic prev_cs = 1, prev_sck = 0, prev_busy = 0, seen = 0, done = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #5 clk = ~clk;

  sram_host_ctrl #(.HALF_CYC(HALF), .GAP_CYC(GAP), .LEN_W(8), .ADDR_W(17)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_width_i(req_width), .req_addr_i(req_addr), .req_len_i(req_len),
    .wdata_i(wdata), .wdata_ack_o(wack), .rdata_o(rdata), .rdata_valid_o(rvalid), .busy_o(busy),
    .sram_cs_no(cs_n), .sram_sck_o(sck), .sio_o(sio_o), .sio_oe_o(sio_oe), .sio_i(sio_in));

  sram_lane_model mdl (.cs_n(cs_n), .sck(sck), .host_o(sio_o), .host_oe(sio_oe),
                       .dout(m_dout), .dout_en(m_en));

  assign sio_in = (m_en & m_dout) | (~m_en & sio_oe & sio_o);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if ((m_en & sio_oe) != 0) conflicts++;
    if (!cs_n && mdl.mode != 2 && !(sio_oe[3] && sio_o[3])) hold_viol++;
    if (busy && req_ready) ready_viol++;
    if (cs_n) begin
      hi_cnt++; run = 0;
    end else begin
      if (prev_cs && seen && hi_cnt < min_gap) min_gap = hi_cnt;
      if (prev_cs) seen = 1;
      if (sck != prev_sck) begin
        if (run < min_half) min_half = run;
        if (run > max_half) max_half = run;
        run = 1;
      end else run++;
      hi_cnt = 0;
    end
    if (prev_busy && !busy && hi_cnt < GAP) busy_gap_bad++;
    prev_cs = cs_n; prev_sck = sck; prev_busy = busy;
  end

  task automatic run_txn(input bit wr, input int w, input int addr, input int n,
                         output int acks, output int nval);
    int guard = 0;
    acks = 0; nval = 0;
    @(negedge clk);
    wdata = wbuf[0]; req_write = wr; req_width = 2'(w); req_addr = 17'(addr);
    req_len = 8'(n - 1); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (busy && guard < 20000) begin
      if (wack) begin acks++; wdata = wbuf[acks < 16 ? acks : 15]; end
      if (rvalid) begin rbuf[nval < 16 ? nval : 15] = rdata; nval++; end
      guard++;
      @(negedge clk);
    end
  endtask

  function automatic int lane_of(input int w);
    return (w == 2) ? 4 : (w == 1) ? 2 : 1;
  endfunction

  initial begin
    int cur = 0;
    int tgts [9] = '{1, 2, 0, 2, 1, 1, 0, 3, 2};
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    // R1
    check(cs_n == 1 && sck == 0, "R1 cs/sck at reset", {cs_n, sck}, 2);
    check(sio_oe == 0 && busy == 0 && req_ready == 1, "R1 oe/busy/ready at reset",
          {sio_oe, busy, req_ready}, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 9; s++) begin
      int t, eff, n, addr, f0, acks, nval, mf, L, d;
      t = tgts[s]; eff = (t == 3) ? 0 : t; n = (s % 4) + 1;
      addr = (s * 4099 + 16'h0120) & 17'h1FFFF;
      mf = (cur == eff) ? 0 : (cur != 0 && eff != 0) ? 2 : 1;
      L = lane_of(eff); d = (eff == 1) ? 4 : (eff == 2) ? 2 : 0;
      for (int k = 0; k < n; k++) wbuf[k] = 8'((s * 37 + k * 11 + 5) & 255);
      f0 = mdl.frames;
      run_txn(1, t, addr, n, acks, nval);
      // R6
      check(mdl.frames - f0 == mf + 1, "R6 frame count on width change", mdl.frames - f0, mf + 1);
      check(mdl.mode == eff, "R6 memory width after change", mdl.mode, eff);
      if (mf > 0)
        check(mdl.mop_log[7:0] == ((eff == 0) ? 8'hFF : (eff == 2) ? 8'h38 : 8'h3B),
              "R6 last mode opcode", mdl.mop_log[7:0], (eff == 0) ? 8'hFF : (eff == 2) ? 8'h38 : 8'h3B);
      if (mf == 2)
        check(mdl.mop_log[15:8] == 8'hFF, "R6 exit opcode before enable", mdl.mop_log[15:8], 8'hFF);
      // R3
      check(mdl.last_rises == 32 / L + n * 8 / L, "R3 write frame edges", mdl.last_rises, 32 / L + n * 8 / L);
      // R8
      check(acks == n, "R8 write ack count", acks, n);
      for (int k = 0; k < n; k++) exp_mem[(addr + k) & 255] = wbuf[k];
      f0 = mdl.frames;
      run_txn(0, t, addr, n, acks, nval);
      check(mdl.frames - f0 == 1, "R6 no mode frame at same width", mdl.frames - f0, 1);
      // R3 R4
      check(mdl.last_rises == 32 / L + d + n * 8 / L, "R4 read frame edges with dummy",
            mdl.last_rises, 32 / L + d + n * 8 / L);
      check(nval == n, "R8 read valid count", nval, n);
      for (int k = 0; k < n; k++)
        // R2
        check(rbuf[k] == exp_mem[(addr + k) & 255], "R2 read-back byte", rbuf[k], exp_mem[(addr + k) & 255]);
      cur = eff;
    end

    begin
      int acks, nval;
      // R8 wrap at top of array in quad width
      run_txn(0, 2, 17'h1FFFE, 3, acks, nval);
      check(nval == 3, "R8 wrap read count", nval, 3);
      check(rbuf[0] == exp_mem[8'hFE], "R8 byte at 1FFFE", rbuf[0], exp_mem[8'hFE]);
      check(rbuf[1] == exp_mem[8'hFF], "R8 byte at 1FFFF", rbuf[1], exp_mem[8'hFF]);
      check(rbuf[2] == exp_mem[8'h00], "R8 byte after wrap", rbuf[2], exp_mem[8'h00]);
      wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
      run_txn(1, 0, 17'h1FFFF, 2, acks, nval);
      check(mdl.mem[8'hFF] == 8'hA5 && mdl.mem[8'h00] == 8'h5A, "R8 single-lane write wrap",
            {mdl.mem[8'hFF], mdl.mem[8'h00]}, 16'hA55A);
    end

    // R7
    check(mdl.oe_viol == 0, "R7 lanes released from first dummy", mdl.oe_viol, 0);
    check(conflicts == 0, "R7 no lane contention", conflicts, 0);
    check(hold_viol == 0, "R7 sio3 held high at single/dual", hold_viol, 0);
    // R2
    check(mdl.addr_err == 0, "R2 address bits 23..17 zero", mdl.addr_err, 0);
    // R5
    check(min_half == HALF && max_half == HALF, "R5 sck phase length", min_half * 256 + max_half, HALF * 257);
    // R9
    check(min_gap >= GAP, "R9 cs high gap", min_gap, GAP);
    // R10
    check(busy_gap_bad == 0 && ready_viol == 0, "R10 busy covers gap", busy_gap_bad + ready_viol, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule